// File: doc/BRIEF.md
# Oversampled Contactless Command Receiver

This block turns a demodulated one-bit stream from a proximity-card front end into command bytes. The line is sampled four times per elementary time unit (etu), with a sample strobe marking each valid sample. The receiver waits for a start-of-frame made of a long low run followed by a rise. It then locks onto the falling edge of each character and takes every bit from the middle of its etu. Each character carries one start bit, eight data bits sent least significant first, and one stop bit.

Each good character is handed to a neighbouring buffer through a one-cycle byte-write port. The port carries the byte's position within the frame. A character that is entirely low closes the frame, and a completion pulse then reports the byte count. Timing violations, malformed characters and buffer overflow abort the frame with an error pulse. A status output shows when a frame is in progress. Checking the frame's CRC belongs to the logic downstream.

The controller has four states:
- HUNT: unsynchronised.
- SOF: timing the low run of a start-of-frame.
- GAP: waiting for the next start bit.
- CHAR: collecting ten bits.

The transitions are:
- HUNT→SOF on a low sample.
- SOF→GAP when the SOF is accepted.
- SOF→HUNT when the SOF is rejected.
- GAP→CHAR on a low sample.
- GAP→HUNT on a gap timeout.
- CHAR→GAP after a data byte.
- CHAR→HUNT on the end-of-frame, a malformed character or overflow.

Top module: `cmd_rx`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) puts the block in HUNT. While reset is applied and after it is released, `in_frame`, `wr_en`, `frame_done` and `rx_err` are low until a frame is received.
- R2: In HUNT, a low sample starts SOF timing; that sample is phase 0 of the first etu. The bit of each etu is taken at phase 2. The SOF is accepted when the first high mid-etu sample follows between 10 and 12 low etus. `in_frame` is high from the clock after that sample.
- R3: An SOF with 9 or fewer low etus, or with a 13th low etu, returns the block to HUNT. This produces no error pulse, and `in_frame` stays low.
- R4: In GAP, a low sample starts a character. Bits are taken at phase 2 of each of ten etus, first in time at bit 0. Bit 0 must be 0 and bit 9 must be 1. The block then pulses `wr_en` with `wr_data` equal to bits 8..1 (the data byte, least significant bit first on the line). `wr_addr` is the byte's zero-based index in the frame.
- R5: In GAP, a 26th consecutive high sample aborts the frame with an `rx_err` pulse and a drop of `in_frame`. A run of 25 high samples is accepted.
- R6: A character with all ten bits 0 ends the frame. If at least one byte was written, the block gives a one-cycle `frame_done` pulse with `frame_len` equal to the byte count, and `in_frame` drops.
- R7: An end-of-frame character that arrives before any byte gives neither `frame_done` nor `rx_err`. It only drops `in_frame`.
- R8: Any other character, that is one that is neither valid data nor all zero, aborts the frame with an `rx_err` pulse.
- R9: When the byte count reaches MAX_BYTES (default 64), that last byte is still written and `rx_err` pulses in the same cycle. The frame is then dropped.
- R10: Cycles with `smp_vld` low change neither the state nor any output, whatever `smp_bit` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_vld | input | 1 | Sample strobe, four per etu |
| smp_bit | input | 1 | Demodulated line level |
| wr_en | output | 1 | Byte-write strobe |
| wr_addr | output | $clog2(MAX_BYTES) | Byte index within the frame |
| wr_data | output | 8 | Received byte |
| frame_done | output | 1 | One-cycle frame completion pulse |
| frame_len | output | $clog2(MAX_BYTES+1) | Byte count, valid with frame_done |
| rx_err | output | 1 | One-cycle abort pulse |
| in_frame | output | 1 | High from SOF acceptance to frame end |

## Verification
The stimulus is built from SOF runs of 9, 10, 12 and 13 etus, which separate the accept and reject edges of the SOF window. Inter-character gaps of 24 and 25 high samples show exactly where the gap timeout sits. Data bytes 0xA5, 0x00, 0xFF and 0x3C expose bit order and stop/start handling. A closing character with no bytes separates a silent resync from completion. A bad stop bit exercises the malformed-character abort, and a 64-byte frame shows the overflow abort coinciding with the final write. One frame is sent with a dead cycle after every sample carrying the inverted bit, which shows that the strobe alone gates the receiver.

// File: rtl/cmd_rx_pkg.sv
package cmd_rx_pkg;
    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_SOF  = 2'd1,
        ST_GAP  = 2'd2,
        ST_CHAR = 2'd3
    } rx_state_t;
endpackage

// File: rtl/rx_shift10.sv
module rx_shift10 #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         shift,
    input  logic         din,
    output logic [W-1:0] q
);
    // new bits enter at the top so the first bit ends at position 0
    always_ff @(posedge clk) begin
        if (rst || clr)
            q <= '0;
        else if (shift)
            q <= {din, q[W-1:1]};
    end
endmodule

// File: rtl/rx_byte_ctr.sv
module rx_byte_ctr #(
    parameter int CW = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          inc,
    output logic [CW-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (inc)
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/cmd_rx.sv
module cmd_rx
    import cmd_rx_pkg::*;
#(
    parameter int MAX_BYTES = 64,
    parameter int SOF_MIN   = 10,
    parameter int SOF_MAX   = 12,
    parameter int GAP_MAX   = 25,
    parameter int SPB       = 4,
    parameter int SMP_AT    = 2,
    parameter int CHW       = 10,
    localparam int AW = $clog2(MAX_BYTES),
    localparam int CW = $clog2(MAX_BYTES + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          smp_vld,
    input  logic          smp_bit,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data,
    output logic          frame_done,
    output logic [CW-1:0] frame_len,
    output logic          rx_err,
    output logic          in_frame
);
    localparam int PW = $clog2(GAP_MAX + SPB + 2);
    localparam int BW = $clog2(((SOF_MAX > CHW) ? SOF_MAX : CHW) + 2);

    localparam logic [PW-1:0] SPB_C    = PW'(SPB);
    localparam logic [PW-1:0] SMP_C    = PW'(SMP_AT);
    localparam logic [PW-1:0] GAP_C    = PW'(GAP_MAX);
    localparam logic [BW-1:0] SOFMIN_C = BW'(SOF_MIN);
    localparam logic [BW-1:0] SOFMAX_C = BW'(SOF_MAX);
    localparam logic [BW-1:0] LAST_C   = BW'(CHW - 1);
    localparam logic [CW-1:0] MAX_C    = CW'(MAX_BYTES);

    rx_state_t st, st_n;
    logic [PW-1:0] pos, pos_n, pinc;
    logic [BW-1:0] bc, bc_n;
    logic [CHW-1:0] sh_q, shv;
    logic [CW-1:0] cnt;
    logic sh_clr, sh_en, cnt_clr, cnt_inc;
    logic wr_n, done_n, err_n;

    rx_shift10 #(.W(CHW)) u_shift (
        .clk(clk), .rst(rst), .clr(sh_clr), .shift(sh_en),
        .din(smp_bit), .q(sh_q)
    );

    rx_byte_ctr #(.CW(CW)) u_cnt (
        .clk(clk), .rst(rst), .clr(cnt_clr), .inc(cnt_inc), .cnt(cnt)
    );

    // character value including the bit sampled this cycle
    assign shv  = {smp_bit, sh_q[CHW-1:1]};
    assign pinc = pos + 1'b1;

    always_comb begin
        st_n    = st;
        pos_n   = pos;
        bc_n    = bc;
        sh_clr  = 1'b0;
        sh_en   = 1'b0;
        cnt_clr = 1'b0;
        cnt_inc = 1'b0;
        wr_n    = 1'b0;
        done_n  = 1'b0;
        err_n   = 1'b0;
        if (smp_vld) begin
            unique case (st)
                ST_HUNT: begin
                    if (!smp_bit) begin
                        st_n  = ST_SOF;
                        pos_n = '0;
                        bc_n  = '0;
                    end
                end
                ST_SOF: begin
                    pos_n = (pinc >= SPB_C) ? '0 : pinc;
                    if (pinc == SMP_C) begin
                        if (!smp_bit) begin
                            bc_n = bc + 1'b1;
                        end else if (bc >= SOFMIN_C) begin
                            st_n    = ST_GAP;
                            pos_n   = '0;
                            cnt_clr = 1'b1;
                        end else begin
                            st_n = ST_HUNT;
                        end
                    end
                    if (bc_n > SOFMAX_C)
                        st_n = ST_HUNT;
                end
                ST_GAP: begin
                    if (smp_bit) begin
                        pos_n = pinc;
                        if (pinc > GAP_C) begin
                            st_n  = ST_HUNT;
                            err_n = 1'b1;
                        end
                    end else begin
                        st_n   = ST_CHAR;
                        pos_n  = '0;
                        bc_n   = '0;
                        sh_clr = 1'b1;
                    end
                end
                ST_CHAR: begin
                    pos_n = (pinc >= SPB_C) ? '0 : pinc;
                    if (pinc == SMP_C) begin
                        sh_en = 1'b1;
                        bc_n  = bc + 1'b1;
                        if (bc == LAST_C) begin
                            if (shv[CHW-1] && !shv[0]) begin
                                wr_n    = 1'b1;
                                cnt_inc = 1'b1;
                                if (cnt + 1'b1 >= MAX_C) begin
                                    st_n  = ST_HUNT;
                                    err_n = 1'b1;
                                end else begin
                                    st_n  = ST_GAP;
                                    pos_n = '0;
                                end
                            end else if (shv == '0) begin
                                st_n   = ST_HUNT;
                                done_n = (cnt != '0);
                            end else begin
                                st_n  = ST_HUNT;
                                err_n = 1'b1;
                            end
                        end
                    end
                end
                default: st_n = ST_HUNT;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= ST_HUNT;
            pos <= '0;
            bc  <= '0;
        end else begin
            st  <= st_n;
            pos <= pos_n;
            bc  <= bc_n;
        end
    end

    // output register
    always_ff @(posedge clk) begin
        if (rst) begin
            wr_en      <= 1'b0;
            wr_addr    <= '0;
            wr_data    <= '0;
            frame_done <= 1'b0;
            frame_len  <= '0;
            rx_err     <= 1'b0;
        end else begin
            wr_en      <= wr_n;
            frame_done <= done_n;
            rx_err     <= err_n;
            if (wr_n) begin
                wr_addr <= cnt[AW-1:0];
                wr_data <= shv[8:1];
            end
            if (done_n)
                frame_len <= cnt;
        end
    end

    assign in_frame = (st == ST_GAP) || (st == ST_CHAR);
endmodule

// File: rtl/cmd_rx_chk.sv
module cmd_rx_chk #(
    parameter int CW = 7
) (
    input logic          clk,
    input logic          rst,
    input logic          smp_vld,
    input logic          smp_bit,
    input logic          wr_en,
    input logic          frame_done,
    input logic [CW-1:0] frame_len,
    input logic          rx_err,
    input logic          in_frame
);
    // R2
    enter_on_high_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(in_frame) |-> ($past(smp_vld) && $past(smp_bit)));

    // R4
    wr_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> $past(in_frame));

    // R6
    done_exit_chk: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> (!in_frame && $past(in_frame) && frame_len != '0));

    // R8
    err_exit_chk: assert property (@(posedge clk) disable iff (rst)
        rx_err |-> (!in_frame && !frame_done));

    // R10
    pulse_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en || frame_done || rx_err) |-> $past(smp_vld));

    // R10
    hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !smp_vld |=> $stable(in_frame));
endmodule

bind cmd_rx cmd_rx_chk #(.CW(CW)) u_chk (
    .clk(clk), .rst(rst), .smp_vld(smp_vld), .smp_bit(smp_bit),
    .wr_en(wr_en), .frame_done(frame_done), .frame_len(frame_len),
    .rx_err(rx_err), .in_frame(in_frame)
);

// File: tb/sim_cmd_rx.sv
module sim_cmd_rx;
    localparam int MAXB = 64;
    localparam int AW = $clog2(MAXB);
    localparam int CW = $clog2(MAXB + 1);
    localparam int E_WR = 1, E_DONE = 2, E_ERR = 4, E_ENTER = 8, E_LEAVE = 16;

    logic clk = 1'b0, rst = 1'b1, smp_vld = 1'b0, smp_bit = 1'b1;
    logic wr_en, frame_done, rx_err, in_frame;
    logic [AW-1:0] wr_addr;
    logic [7:0] wr_data;
    logic [CW-1:0] frame_len;

    cmd_rx #(.MAX_BYTES(MAXB)) u0 (
        .clk(clk), .rst(rst), .smp_vld(smp_vld), .smp_bit(smp_bit),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .frame_done(frame_done), .frame_len(frame_len),
        .rx_err(rx_err), .in_frame(in_frame)
    );

    always #2 clk = ~clk;

    int errors = 0, checks = 0;
    string cur_req = "R1";

    // stimulus and expected-event model, keyed by sample index
    bit bitq[$];
    int ev[int];
    int ev_dat[int];
    int ev_adr[int];
    int ev_len[int];
    int cnt_m = 0, run_m = 0;
    bit frm = 0;
    bit in_m = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp_v, input string what);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp_v);
        end
    endtask

    task automatic g_high(input int n);
        for (int k = 0; k < n; k++) begin
            bitq.push_back(1'b1);
            if (frm) begin
                run_m++;
                if (run_m == 26) begin
                    ev[bitq.size() - 1] = E_ERR;
                    frm = 0;
                end
            end
        end
    endtask

    task automatic g_sof(input int etus, input int highs);
        for (int k = 0; k < 4 * etus; k++) bitq.push_back(1'b0);
        for (int k = 0; k < 3; k++) bitq.push_back(1'b1);
        if (etus >= 10 && etus <= 12) begin
            ev[bitq.size() - 1] = E_ENTER;
            frm = 1;
            cnt_m = 0;
            run_m = 0;
        end
        g_high(highs - 3);
    endtask

    // v[0] is the first bit in time
    task automatic g_char(input logic [9:0] v);
        int e;
        e = bitq.size() + 38;
        for (int b = 0; b < 10; b++)
            for (int k = 0; k < 4; k++) bitq.push_back(v[b]);
        if (!frm) return;
        if (v[9] && !v[0]) begin
            ev[e] = E_WR;
            ev_dat[e] = int'(v[8:1]);
            ev_adr[e] = cnt_m;
            cnt_m++;
            if (cnt_m >= MAXB) begin
                ev[e] = E_WR | E_ERR;
                frm = 0;
            end else begin
                run_m = 1;
            end
        end else if (v == 10'd0) begin
            ev[e] = (cnt_m != 0) ? E_DONE : E_LEAVE;
            ev_len[e] = cnt_m;
            frm = 0;
        end else begin
            ev[e] = E_ERR;
            frm = 0;
        end
    endtask

    task automatic g_byte(input logic [7:0] b, input int gap);
        g_char({1'b1, b, 1'b0});
        g_high(gap);
    endtask

    task automatic cmp(input int idx);
        int m;
        m = (idx >= 0 && ev.exists(idx)) ? ev[idx] : 0;
        if ((m & E_ENTER) != 0) in_m = 1;
        if ((m & (E_DONE | E_ERR | E_LEAVE)) != 0) in_m = 0;
        check(in_frame == in_m, cur_req, int'(in_frame), int'(in_m), "in_frame");
        check(wr_en == ((m & E_WR) != 0), cur_req, int'(wr_en), int'((m & E_WR) != 0), "wr_en");
        if ((m & E_WR) != 0 && wr_en) begin
            check(int'(wr_data) == ev_dat[idx], cur_req, int'(wr_data), ev_dat[idx], "wr_data");
            check(int'(wr_addr) == ev_adr[idx], cur_req, int'(wr_addr), ev_adr[idx], "wr_addr");
        end
        check(frame_done == ((m & E_DONE) != 0), cur_req, int'(frame_done), int'((m & E_DONE) != 0), "frame_done");
        if ((m & E_DONE) != 0 && frame_done)
            check(int'(frame_len) == ev_len[idx], cur_req, int'(frame_len), ev_len[idx], "frame_len");
        check(rx_err == ((m & E_ERR) != 0), cur_req, int'(rx_err), int'((m & E_ERR) != 0), "rx_err");
    endtask

    task automatic play(input bit stall);
        for (int i = 0; i < bitq.size(); i++) begin
            @(negedge clk);
            smp_vld = 1'b1;
            smp_bit = bitq[i];
            @(posedge clk);
            #1 cmp(i);
            if (stall) begin
                @(negedge clk);
                smp_vld = 1'b0;
                smp_bit = ~bitq[i];
                @(posedge clk);
                #1 cmp(-1);
            end
        end
        @(negedge clk);
        smp_vld = 1'b0;
        smp_bit = 1'b1;
        bitq.delete();
        ev.delete();
        ev_dat.delete();
        ev_adr.delete();
        ev_len.delete();
        frm = 0;
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        #1 cmp(-1);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1 cmp(-1);

        // R2 R4 R6: minimal SOF, three bytes
        cur_req = "R4";
        g_high(8);
        g_sof(10, 8);
        g_byte(8'hA5, 0);
        g_byte(8'h00, 0);
        g_byte(8'hFF, 0);
        g_char(10'd0);
        g_high(12);
        play(0);

        // R2 R5: longest SOF, longest allowed gap
        cur_req = "R5";
        g_sof(12, 8);
        g_byte(8'h3C, 24);
        g_byte(8'h81, 0);
        g_char(10'd0);
        g_high(12);
        play(0);

        // R3: SOF too short, then too long
        cur_req = "R3";
        g_sof(9, 20);
        g_high(8);
        g_sof(13, 20);
        g_high(8);
        play(0);

        // R7: empty frame
        cur_req = "R7";
        g_sof(11, 8);
        g_char(10'd0);
        g_high(12);
        play(0);

        // R5: gap of 25 high samples aborts
        cur_req = "R5";
        g_sof(10, 8);
        g_byte(8'h5A, 25);
        g_high(10);
        play(0);

        // R8: bad stop bit
        cur_req = "R8";
        g_sof(10, 8);
        g_byte(8'h12, 0);
        g_char({1'b0, 8'h34, 1'b0});
        g_high(12);
        play(0);

        // R9: overflow at MAXB bytes
        cur_req = "R9";
        g_sof(10, 8);
        for (int k = 0; k < MAXB; k++) g_byte(8'(k * 7 + 3), 0);
        g_high(12);
        play(0);

        // R10: dead cycles with inverted bit between samples
        cur_req = "R10";
        g_sof(10, 8);
        g_byte(8'hC3, 2);
        g_byte(8'h6E, 0);
        g_char(10'd0);
        g_high(12);
        play(1);

        // R6: frame after the stalled one, back to back timing
        cur_req = "R6";
        g_sof(10, 8);
        g_byte(8'h01, 0);
        g_char(10'd0);
        g_high(12);
        play(0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule